// File: doc/BRIEF.md
# Four-Lane Same-Cycle Register Renamer

This block maps architectural register numbers to physical register numbers for a group of up to four instructions in a single cycle. Each lane presents a valid flag, two source register numbers, a destination register number and a flag saying whether it writes a destination. The block answers in the same cycle with the physical source registers, a freshly allocated physical destination and the physical register that the destination was mapped to before this write. That last value lets a later stage release the register once the instruction retires.

The lanes of a group are ordered from lane 0, the oldest, to lane 3, the youngest. Dependences inside the group are resolved by forwarding. A source or an old-destination lookup that names a register written by an older lane in the same group receives that lane's new physical register instead of the table entry. An external free list offers up to four physical registers together with a count of how many are usable. The group either renames completely or stalls completely. The mapping table is written at the clock edge that ends an accepted group. When several lanes write one register, the youngest lane's mapping is the one stored. Reset loads the identity mapping.

Top module: `rename4`

## Requirements
- R1: After reset, every architectural register a maps to physical register a, so every source port returns its own register number.
- R2: A source whose register is written by no older lane of the group returns the mapping held in the table.
- R3: A source whose register is written by an older lane of the group returns the new physical register of the nearest such older lane. For example, if lanes 0 and 2 both write register r and lane 3 reads r, lane 3 receives lane 2's register.
- R4: A lane allocates when it is valid, has a destination and the destination is not register 0. The allocating lanes, taken in order from lane 0, receive free-list slots 0, 1, 2 and so on, where slot k occupies bits [k*PW +: PW] of the free-list input.
- R5: The old-mapping output of an allocating lane equals the new register of the nearest older lane writing the same register, or the table entry if there is no such lane.
- R6: When the free count is lower than the number of allocating lanes, the stall output is 1, the used count is 0 and the table is left unchanged. Otherwise the stall output is 0 and the used count equals the number of allocating lanes.
- R7: After an accepted group, each register the group wrote maps to the new register of the youngest lane that wrote it.
- R8: Register 0 always maps to physical register 0. A lane whose destination is register 0 allocates nothing, and it outputs 0 as both new and old destination.
- R9: A lane that does not allocate outputs 0 as new and old destination and does not forward to younger lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | LANES | Lane holds an instruction |
| in_has_dst | input | LANES | Lane writes a destination |
| in_src1 | input | LANES*AW | First source register per lane |
| in_src2 | input | LANES*AW | Second source register per lane |
| in_dst | input | LANES*AW | Destination register per lane |
| free_count | input | CW | Number of usable free-list slots (0 to LANES) |
| free_pregs | input | LANES*PW | Free physical registers, slot 0 in the low bits |
| out_stall | output | 1 | Group cannot be renamed this cycle |
| alloc_used | output | CW | Free-list slots consumed this cycle |
| out_psrc1 | output | LANES*PW | Physical first source per lane |
| out_psrc2 | output | LANES*PW | Physical second source per lane |
| out_pdst | output | LANES*PW | New physical destination per lane |
| out_pold | output | LANES*PW | Prior physical mapping of the destination |

## Verification
The assertions assume a well-behaved free list. The free count never exceeds LANES. Every offered slot holds a nonzero physical register below NPHYS. The bench's pool hands out numbers from 1 to 63 in rotation, so register 0 is never offered, and it draws free counts from 0 to 4. Destinations and sources are mostly drawn from registers 0 to 3 so that in-group conflicts and repeated writes occur often.

// File: rtl/rename4.sv
module rename4 #(
  parameter int LANES = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 64,
  localparam int AW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES-1:0]    in_has_dst,
  input  logic [LANES*AW-1:0] in_src1,
  input  logic [LANES*AW-1:0] in_src2,
  input  logic [LANES*AW-1:0] in_dst,
  input  logic [CW-1:0]       free_count,
  input  logic [LANES*PW-1:0] free_pregs,
  output logic                out_stall,
  output logic [CW-1:0]       alloc_used,
  output logic [LANES*PW-1:0] out_psrc1,
  output logic [LANES*PW-1:0] out_psrc2,
  output logic [LANES*PW-1:0] out_pdst,
  output logic [LANES*PW-1:0] out_pold
);

  logic [PW-1:0]    map_q [NARCH];
  logic [LANES-1:0] need;
  logic [CW-1:0]    need_cnt;
  logic [PW-1:0]    pdst_w [LANES];
  logic [AW-1:0]    dst_w  [LANES];
  logic             fire;

  always_comb begin
    logic [CW-1:0] cnt;
    logic [AW-1:0] s1, s2;
    logic [PW-1:0] r1, r2, ro;
    cnt = '0;
    out_psrc1 = '0;
    out_psrc2 = '0;
    out_pdst  = '0;
    out_pold  = '0;
    for (int i = 0; i < LANES; i++) begin
      dst_w[i] = in_dst[i*AW +: AW];
      need[i]  = in_valid[i] & in_has_dst[i] & (dst_w[i] != '0);
      pdst_w[i] = need[i] ? free_pregs[int'(cnt)*PW +: PW] : '0;
      cnt = cnt + CW'(need[i]);
    end
    need_cnt = cnt;
    for (int i = 0; i < LANES; i++) begin
      s1 = in_src1[i*AW +: AW];
      s2 = in_src2[i*AW +: AW];
      r1 = map_q[s1];
      r2 = map_q[s2];
      ro = map_q[dst_w[i]];
      for (int j = 0; j < i; j++) begin
        if (need[j] && dst_w[j] == s1) r1 = pdst_w[j];
        if (need[j] && dst_w[j] == s2) r2 = pdst_w[j];
        if (need[j] && dst_w[j] == dst_w[i]) ro = pdst_w[j];
      end
      out_psrc1[i*PW +: PW] = r1;
      out_psrc2[i*PW +: PW] = r2;
      out_pdst[i*PW +: PW]  = pdst_w[i];
      out_pold[i*PW +: PW]  = need[i] ? ro : '0;
    end
  end

  assign out_stall  = need_cnt > free_count;
  assign fire       = !out_stall;
  assign alloc_used = fire ? need_cnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) map_q[a] <= PW'(a);
    end else if (fire) begin
      for (int i = 0; i < LANES; i++)
        if (need[i]) map_q[dst_w[i]] <= pdst_w[i];
    end
  end

  assert_zero_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[0] == '0);

  assert_alloc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stall |-> alloc_used <= free_count);

  assert_no_grant_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> alloc_used == '0);

  assert_youngest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire) && $past(need[LANES-1])) |->
      map_q[$past(dst_w[LANES-1])] == $past(pdst_w[LANES-1]));

endmodule

// File: tb/rename4_tb_top.sv
module rename4_tb_top;
  localparam int L = 4, AW = 5, PW = 6, CW = 3;

  logic clk = 0, rst_n = 0;
  logic [L-1:0] in_valid = '0, in_has_dst = '0;
  logic [L*AW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [CW-1:0] free_count = '0;
  logic [L*PW-1:0] free_pregs = '0;
  logic out_stall;
  logic [CW-1:0] alloc_used;
  logic [L*PW-1:0] out_psrc1, out_psrc2, out_pdst, out_pold;

  rename4 dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .free_count(free_count),
    .free_pregs(free_pregs), .out_stall(out_stall), .alloc_used(alloc_used),
    .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_pdst(out_pdst), .out_pold(out_pold));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int ref_map [32];
  int base = 0;
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'(lcg[30:16]) % m;
  endfunction

  function automatic int pick_reg();
    return (rnd(4) != 0) ? rnd(4) : rnd(32);
  endfunction

  task automatic load_pool(input int fc);
    free_count = CW'(fc);
    for (int k = 0; k < L; k++) free_pregs[k*PW +: PW] = PW'(1 + ((base + k) % 63));
  endtask

  // apply current inputs, check all outputs against the model, then clock
  task automatic run_cycle();
    int nd [L]; int dd [L]; int pd [L]; int cnt; bit stall; int v; int sr;
    #1;
    cnt = 0;
    for (int i = 0; i < L; i++) begin
      dd[i] = int'(in_dst[i*AW +: AW]);
      nd[i] = (in_valid[i] && in_has_dst[i] && dd[i] != 0) ? 1 : 0;
      pd[i] = nd[i] ? int'(free_pregs[cnt*PW +: PW]) : 0;
      cnt += nd[i];
    end
    stall = cnt > int'(free_count);
    chk("R6", "stall", int'(out_stall), int'(stall));
    chk("R6", "alloc_used", int'(alloc_used), stall ? 0 : cnt);
    for (int i = 0; i < L; i++) begin
      for (int s = 0; s < 2; s++) begin
        bit fw;
        sr = (s == 0) ? int'(in_src1[i*AW +: AW]) : int'(in_src2[i*AW +: AW]);
        v = ref_map[sr]; fw = 0;
        for (int j = 0; j < i; j++) if (nd[j] == 1 && dd[j] == sr) begin v = pd[j]; fw = 1; end
        chk(sr == 0 ? "R8" : (fw ? "R3" : "R2"), "psrc",
            s == 0 ? int'(out_psrc1[i*PW +: PW]) : int'(out_psrc2[i*PW +: PW]), v);
      end
      if (nd[i] == 1) begin
        v = ref_map[dd[i]];
        for (int j = 0; j < i; j++) if (nd[j] == 1 && dd[j] == dd[i]) v = pd[j];
        chk("R4", "pdst", int'(out_pdst[i*PW +: PW]), pd[i]);
        chk("R5", "pold", int'(out_pold[i*PW +: PW]), v);
      end else begin
        chk(dd[i] == 0 ? "R8" : "R9", "pdst idle", int'(out_pdst[i*PW +: PW]), 0);
        chk(dd[i] == 0 ? "R8" : "R9", "pold idle", int'(out_pold[i*PW +: PW]), 0);
      end
    end
    @(posedge clk);
    if (!stall) begin
      for (int i = 0; i < L; i++) if (nd[i] == 1) ref_map[dd[i]] = pd[i];
      base += cnt;
    end
    @(negedge clk);
  endtask

  task automatic read_all(input string req);
    in_valid = '0;
    for (int g = 0; g < 32 / L; g++) begin
      for (int i = 0; i < L; i++) begin
        in_src1[i*AW +: AW] = AW'(g*L + i);
        in_src2[i*AW +: AW] = AW'(31 - g*L - i);
      end
      #1;
      for (int i = 0; i < L; i++) begin
        chk(req, "table src1", int'(out_psrc1[i*PW +: PW]), ref_map[g*L + i]);
        chk(req, "table src2", int'(out_psrc2[i*PW +: PW]), ref_map[31 - g*L - i]);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) ref_map[a] = a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: identity after reset
    read_all("R1");
    // R3: lanes 0 and 2 write r5, lane 3 reads r5 and must see lane 2
    load_pool(4);
    in_valid = 4'b1111; in_has_dst = 4'b0101;
    in_dst = {5'd0, 5'd5, 5'd0, 5'd5};
    in_src1 = {5'd5, 5'd5, 5'd5, 5'd5};
    in_src2 = {5'd0, 5'd7, 5'd0, 5'd9};
    #1;
    chk("R3", "lane3 reads lane2", int'(out_psrc1[3*PW +: PW]), int'(free_pregs[1*PW +: PW]));
    chk("R3", "lane1 reads lane0", int'(out_psrc1[1*PW +: PW]), int'(free_pregs[0*PW +: PW]));
    run_cycle();
    // R6: stall leaves table untouched
    load_pool(1);
    in_valid = 4'b1111; in_has_dst = 4'b1111;
    in_dst = {5'd1, 5'd2, 5'd3, 5'd4};
    run_cycle();
    read_all("R6");
    // sweep
    for (int n = 0; n < 3000; n++) begin
      load_pool(rnd(3) == 0 ? rnd(5) : 4);
      for (int i = 0; i < L; i++) begin
        in_valid[i]   = rnd(4) != 0;
        in_has_dst[i] = rnd(4) != 0;
        in_dst[i*AW +: AW]  = AW'(pick_reg());
        in_src1[i*AW +: AW] = AW'(pick_reg());
        in_src2[i*AW +: AW] = AW'(pick_reg());
      end
      run_cycle();
    end
    // R7: table reflects youngest writers
    read_all("R7");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule